// File: doc/BRIEF.md
# Register-Write Coalescing Command Packer

This block turns a stream of register-write requests into two-word instructions in a local command buffer. Each request carries a 20-bit register offset, 32-bit data and a 32-bit mask. A partial mask becomes a direct write with byte enables. A full-mask write to the same register as the instruction just emitted is folded into that instruction. When the open instruction is a direct write, the block rewrites it in place into an indexed write. When it is already an indexed write, the block appends the data word and bumps the count. A run of writes to one register therefore costs one header and one word per value.

Requests arrive on a valid/ready handshake. The block drops ready while it performs its multi-cycle write sequences on the single write port of the buffer. A finish request zero-fills the buffer up to the next 16-word (64-byte) line and reports the tail in bytes. A clear input empties the buffer logically. A separate read port lets a downstream executor, or a bench, inspect the buffer words.

Top module: `cmd_packer`

## Requirements
- R1: The 4-bit byte enable placed in header bits [23:20] has bit k set exactly when any bit of mask byte k (mask bits [8k+7:8k]) is set.
- R2: A new direct write occupies two words. The lower address holds the data. The upper address holds opcode 0x01 in bits [31:24], the byte enable in [23:20] and the offset in [19:0].
- R3: A full-mask write whose offset matches an open full-enable direct write converts it in place. With the instruction starting at word s: s holds count 2, s+1 holds opcode 0x09 with bits [23:20] zero and the offset, s+2 holds the earlier data and s+3 holds the new data.
- R4: A full-mask write whose offset matches an open indexed write stores its data at the free pointer, advances the pointer, and raises the count word at the instruction start by one. If the pointer is then odd, the word at the pointer is written to zero. If it is even, that word is left untouched.
- R5: A write with any mask byte empty never merges. A later full-mask write to the same offset does not merge into it either; each produces its own direct write.
- R6: A write to a different offset opens a new instruction at the free pointer rounded up to an even word.
- R7: When the buffer is empty, after reset or clear, the first write always opens a direct write at word 0, whatever the buffer RAM holds.
- R8: A request is rejected when fewer than two words remain beyond the free pointer, rounded up to even for a new instruction. A rejected request is still consumed, overflow_o pulses in the following cycle, and the buffer is not written.
- R9: On finish, the words from the free pointer up to the next 16-word boundary are zeroed. tail_valid_o then pulses with tail_bytes_o equal to four times the aligned word count. An already aligned pointer writes nothing.
- R10: req_ready_o is low in the cycle after an accepted request that needs a write sequence, and a request is taken only when valid and ready are both high.
- R11: clear_i returns the free pointer and the instruction-start pointer to zero, so the next instruction starts at word 0.
- R12: Finish closes the open instruction, so a matching full-mask write after finish opens a new direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the pointers and the open instruction |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Block can take a request or finish |
| req_ofs_i | input | 20 | Register offset |
| req_data_i | input | 32 | Write data |
| req_mask_i | input | 32 | Bit mask, turned into byte enables |
| fin_i | input | 1 | Finish request, taken when ready and no write request is valid |
| overflow_o | output | 1 | One-cycle pulse after a rejected request |
| tail_valid_o | output | 1 | One-cycle pulse when finish completes |
| tail_bytes_o | output | 9 | Aligned buffer length in bytes |
| rd_addr_i | input | 6 | Inspection read address (word) |
| rd_data_o | output | 32 | Buffer word at rd_addr_i |

## Verification
The hardest case to reach is the merge boundary. A matching write must be refused for lack of room while a direct write is open in the last two words of the buffer, and the refusal must leave the header unconverted. The bench reaches it by filling the buffer with distinct-offset writes until the free pointer sits exactly at the end. It then sends a write that repeats the last offset with a full mask. The empty-buffer rule is driven in a similar way. The instruction just before a clear is a full direct write to the same offset as the first write after the clear, so a design that kept stale merge state would visibly convert word 0.

// File: rtl/cmd_packer_pkg.sv
package cmd_packer_pkg;
  localparam int OFS_W  = 20;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  typedef enum logic [1:0] {PREV_NONE, PREV_FULL, PREV_IDX} prev_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEW_LO, ST_NEW_HI, ST_CV_MOVE, ST_CV_HDR,
    ST_MG_DATA, ST_MG_CNT, ST_MG_PAD, ST_FILL
  } st_e;
endpackage

// File: rtl/cmd_packer_bytemask.sv
module cmd_packer_bytemask
  import cmd_packer_pkg::*;
(
  input  logic [WORD_W-1:0] mask_i,
  output logic [BE_W-1:0]   be_o
);
  for (genvar k = 0; k < BE_W; k++) begin : g_lane
    assign be_o[k] = |mask_i[8*k +: 8];
  end
endmodule

// File: rtl/cmd_packer_ram.sv
module cmd_packer_ram
  import cmd_packer_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  assert_waddr_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(waddr_i) < DEPTH));
endmodule

// File: rtl/cmd_packer_ctrl.sv
module cmd_packer_ctrl
  import cmd_packer_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int LB = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OFS_W-1:0]  req_ofs_i,
  input  logic [WORD_W-1:0] req_data_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic              fin_i,
  output logic              overflow_o,
  output logic              tail_valid_o,
  output logic [PW+1:0]     tail_bytes_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o
);
  st_e               st_q;
  prev_e             prev_q;
  logic [PW-1:0]     free_q, start_q, dat_addr_q;
  logic [OFS_W-1:0]  ofs_q, prev_ofs_q;
  logic [WORD_W-1:0] data_q, prev_data_q, cnt_q;
  logic [BE_W-1:0]   be_q;
  logic              ovf_q, tail_v_q;
  logic [PW+1:0]     tail_q;

  logic              full, can_merge, room_mrg, room_new;
  logic [PW-1:0]     free_even;

  assign full      = &req_be_i;
  assign can_merge = full && (prev_q != PREV_NONE) && (prev_ofs_q == req_ofs_i);
  assign free_even = free_q + PW'(free_q[0]);
  assign room_mrg  = free_q <= PW'(DEPTH - 2);
  assign room_new  = free_even <= PW'(DEPTH - 2);

  assign req_ready_o  = (st_q == ST_IDLE);
  assign overflow_o   = ovf_q;
  assign tail_valid_o = tail_v_q;
  assign tail_bytes_o = tail_q;

  always_comb begin
    ram_we_o    = 1'b1;
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    unique case (st_q)
      ST_NEW_LO:  begin ram_addr_o = AW'(start_q);            ram_wdata_o = data_q; end
      ST_NEW_HI:  begin ram_addr_o = AW'(start_q + PW'(1));   ram_wdata_o = {OP_DIRECT, be_q, ofs_q}; end
      ST_CV_MOVE: begin ram_addr_o = AW'(start_q + PW'(2));   ram_wdata_o = prev_data_q; end
      ST_CV_HDR:  begin ram_addr_o = AW'(start_q + PW'(1));   ram_wdata_o = {OP_INDEXED, 4'h0, ofs_q}; end
      ST_MG_DATA: begin ram_addr_o = AW'(dat_addr_q);         ram_wdata_o = data_q; end
      ST_MG_CNT:  begin ram_addr_o = AW'(start_q);            ram_wdata_o = cnt_q; end
      ST_MG_PAD:  ram_addr_o = AW'(free_q);
      ST_FILL: begin
        ram_we_o   = free_q[LB-1:0] != '0;
        ram_addr_o = AW'(free_q);
      end
      default: ram_we_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; prev_q <= PREV_NONE;
      free_q <= '0; start_q <= '0; dat_addr_q <= '0;
      ofs_q <= '0; prev_ofs_q <= '0; data_q <= '0; prev_data_q <= '0;
      cnt_q <= '0; be_q <= '0; ovf_q <= 1'b0; tail_v_q <= 1'b0; tail_q <= '0;
    end else if (clear_i) begin
      st_q <= ST_IDLE; prev_q <= PREV_NONE;
      free_q <= '0; start_q <= '0;
      ovf_q <= 1'b0; tail_v_q <= 1'b0;
    end else begin
      ovf_q    <= 1'b0;
      tail_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            ofs_q  <= req_ofs_i;
            data_q <= req_data_i;
            be_q   <= req_be_i;
            if (can_merge) begin
              if (!room_mrg) ovf_q <= 1'b1;
              else begin
                prev_q <= PREV_IDX;
                if (prev_q == PREV_FULL) begin
                  // instruction occupies start..start+1, free == start+2
                  dat_addr_q <= free_q + PW'(1);
                  free_q     <= free_q + PW'(2);
                  cnt_q      <= 32'd2;
                  st_q       <= ST_CV_MOVE;
                end else begin
                  dat_addr_q <= free_q;
                  free_q     <= free_q + PW'(1);
                  cnt_q      <= cnt_q + 32'd1;
                  st_q       <= ST_MG_DATA;
                end
              end
            end else if (!room_new) ovf_q <= 1'b1;
            else begin
              start_q     <= free_even;
              free_q      <= free_even + PW'(2);
              prev_q      <= full ? PREV_FULL : PREV_NONE;
              prev_ofs_q  <= req_ofs_i;
              prev_data_q <= req_data_i;
              st_q        <= ST_NEW_LO;
            end
          end else if (fin_i) begin
            prev_q <= PREV_NONE;
            st_q   <= ST_FILL;
          end
        end
        ST_NEW_LO:  st_q <= ST_NEW_HI;
        ST_CV_MOVE: st_q <= ST_CV_HDR;
        ST_CV_HDR:  st_q <= ST_MG_DATA;
        ST_MG_DATA: st_q <= ST_MG_CNT;
        ST_MG_CNT:  st_q <= free_q[0] ? ST_MG_PAD : ST_IDLE;
        ST_FILL: begin
          if (free_q[LB-1:0] != '0) free_q <= free_q + PW'(1);
          else begin
            tail_v_q <= 1'b1;
            tail_q   <= {free_q, 2'b00};
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_clear_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (free_q == '0 && start_q == '0));
  assert_free_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_q) <= DEPTH);
  assert_start_le_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q <= free_q);
  assert_ovf_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(req_valid_i && req_ready_o));
  assert_tail_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_valid_o |-> (tail_bytes_o[LB+1:0] == '0));
  assert_busy_after_merge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !clear_i && can_merge && room_mrg) |=> !req_ready_o);
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmd_packer_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OFS_W-1:0]  req_ofs_i,
  input  logic [WORD_W-1:0] req_data_i,
  input  logic [WORD_W-1:0] req_mask_i,
  input  logic              fin_i,
  output logic              overflow_o,
  output logic              tail_valid_o,
  output logic [PW+1:0]     tail_bytes_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [BE_W-1:0]   be;
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [WORD_W-1:0] ram_wdata;

  cmd_packer_bytemask u_be (.mask_i(req_mask_i), .be_o(be));

  cmd_packer_ctrl #(.DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .clear_i, .req_valid_i, .req_ready_o,
    .req_ofs_i, .req_data_i, .req_be_i(be), .fin_i,
    .overflow_o, .tail_valid_o, .tail_bytes_o,
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata)
  );

  cmd_packer_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i, .rst_ni, .we_i(ram_we), .waddr_i(ram_addr), .wdata_i(ram_wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/tb_cmd_packer.sv
`timescale 1ns/1ps
module tb_cmd_packer;
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0, clear = 0, req_valid = 0, fin = 0;
  logic [19:0] ofs = 0;
  logic [31:0] data = 0, mask = 0;
  logic ready, ovf, tail_valid;
  logic [8:0] tail_bytes;
  logic [5:0] rd_addr = 0;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  logic last_ovf, last_rdy;
  logic [8:0] last_tail;

  cmd_packer dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .req_valid_i(req_valid),
    .req_ready_o(ready), .req_ofs_i(ofs), .req_data_i(data), .req_mask_i(mask),
    .fin_i(fin), .overflow_o(ovf), .tail_valid_o(tail_valid),
    .tail_bytes_o(tail_bytes), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic word(input string req, input int a, input logic [31:0] exp);
    rd_addr = 6'(a);
    #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic send(input logic [19:0] o, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; ofs = o; data = d; mask = m;
    @(negedge clk);
    req_valid = 0;
    last_ovf = ovf;
    last_rdy = ready;
    while (!ready) @(negedge clk);
  endtask

  task automatic finish_buf();
    int n = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    fin = 1;
    @(negedge clk);
    fin = 0;
    while (!tail_valid && n < 100) begin @(negedge clk); n++; end
    last_tail = tail_valid ? tail_bytes : 9'h1FF;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  task automatic t_reset();
    check("R10 ready after reset", 32'(ready), 1);
    check("R8 no overflow after reset", 32'(ovf), 0);
    finish_buf();
    check("R9 empty finish tail", 32'(last_tail), 0);
  endtask

  task automatic t_direct();
    send(20'h12345, 32'hAAAA5555, 32'h00FF0F00);
    check("R10 ready low during sequence", 32'(last_rdy), 0);
    word("R2 direct data", 0, 32'hAAAA5555);
    word("R1 byte enable", 1, 32'h01612345);
    send(20'h00001, 32'h11110001, FULL);
    send(20'h00002, 32'h22220002, FULL);
    send(20'h00003, 32'h33330003, FULL);
    send(20'h00777, 32'h77770000, FULL);
    word("R6 new at 2", 2, 32'h11110001);
    word("R6 hdr at 3", 3, 32'h01F00001);
    word("R6 hdr at 7", 7, 32'h01F00003);
    word("R6 hdr at 9", 9, 32'h01F00777);
  endtask

  task automatic t_clear_merge();
    do_clear();
    send(20'h00777, 32'hD1D1D1D1, FULL);
    word("R7 data at 0", 0, 32'hD1D1D1D1);
    word("R7 R11 direct hdr at 1", 1, 32'h01F00777);
    send(20'h00777, 32'hD2D2D2D2, FULL);
    word("R3 count", 0, 2);
    word("R3 indexed hdr", 1, 32'h09000777);
    word("R3 moved data", 2, 32'hD1D1D1D1);
    word("R3 new data", 3, 32'hD2D2D2D2);
    send(20'h00777, 32'hD3D3D3D3, FULL);
    word("R4 appended", 4, 32'hD3D3D3D3);
    word("R4 count 3", 0, 3);
    word("R4 odd pad", 5, 0);
    send(20'h00042, 32'hEEEE0042, FULL);
    word("R6 rounded start", 6, 32'hEEEE0042);
    word("R6 rounded hdr", 7, 32'h01F00042);
    word("R6 pad kept", 5, 0);
  endtask

  task automatic t_finish();
    finish_buf();
    check("R9 tail bytes", 32'(last_tail), 64);
    for (int i = 8; i < 16; i++) word("R9 zero fill", i, 0);
    send(20'h00042, 32'h0000ABCD, FULL);
    word("R12 new after finish", 16, 32'h0000ABCD);
    word("R12 direct hdr", 17, 32'h01F00042);
  endtask

  task automatic t_partial();
    send(20'h00042, 32'h00000012, 32'h000000FF);
    word("R5 partial own instr", 18, 32'h00000012);
    word("R5 R1 partial hdr", 19, 32'h01100042);
    send(20'h00042, 32'h00000034, FULL);
    word("R5 full after partial", 20, 32'h00000034);
    word("R5 full hdr", 21, 32'h01F00042);
    send(20'h00042, 32'h00000056, FULL);
    send(20'h00042, 32'h00000078, FULL);
    word("R4 pad at 25", 25, 0);
    send(20'h00042, 32'h0000009A, FULL);
    word("R4 even no pad, data", 25, 32'h0000009A);
    word("R4 count 4", 20, 4);
    word("R3 second conversion hdr", 21, 32'h09000042);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 19; i++) send(20'h00100 + 20'(i), 32'h5000_0000 + 32'(i), FULL);
    check("R8 last fit accepted", 32'(last_ovf), 0);
    word("R8 last hdr", 63, 32'h01F00112);
    send(20'h00200, 32'hBAD0BAD0, FULL);
    check("R8 new rejected", 32'(last_ovf), 1);
    send(20'h00112, 32'hBAD1BAD1, FULL);
    check("R8 merge rejected", 32'(last_ovf), 1);
    word("R8 hdr untouched", 63, 32'h01F00112);
    word("R8 data untouched", 62, 32'h50000012);
    finish_buf();
    check("R9 full tail", 32'(last_tail), 256);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_clear_merge();
    t_finish();
    t_partial();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule